// File: doc/BRIEF.md
# Nibble-Serial Register Access Port

This block turns a stream of command bytes into accesses to a 256-entry register file. Each command byte splits into two halves. The upper four bits select an operation. The lower four bits carry a payload nibble. A full register address is built from two commands: the low half comes first and the high half second. Write data is built the same way. The lower data nibble waits in a staging register, and the upper data nibble completes the byte and performs the write.

The address stays where it is after a write. This lets a run of data bytes be poured into one register, for example to fill a table through a single data port. Reads come in two kinds. A plain read returns the addressed register. A read with post-increment returns the addressed register and then steps the address by one. A host can therefore stream out adjacent registers, such as two 24-bit position counters stored least significant byte first, with six commands in a row. The register file itself sits outside the block and is reached through a plain address / write / read-data port.

Top module: `nibble_reg_port`

## Requirements
- R1: The opcode is `cmd_byte[7:4]` and the payload nibble is `cmd_byte[3:0]`. The opcodes are: 0x0 sets the address low nibble, 0x1 sets the address high nibble, 0x2 stages the data low nibble, 0x3 supplies the data high nibble and writes, 0x4 reads, and 0x5 reads with post-increment.
- R2: An address-low command replaces `reg_addr[3:0]` and an address-high command replaces `reg_addr[7:4]`. The other half is kept. `reg_addr` shows the new address from the cycle after the command.
- R3: A data-high command that follows a staged data-low nibble raises `reg_wr_en` in the same cycle as the command. It writes `{high, low}` to the current `reg_addr`.
- R4: A write leaves the address unchanged. Several low/high data pairs after one address all write that same register, one write for each high command.
- R5: A data-high command with no staged low nibble writes nothing. An address-low command discards any staged low nibble. A completed write also consumes the staged nibble.
- R6: A read (0x4) makes `rsp_valid` high for exactly the next cycle. `rsp_byte` carries the register at the address current in the command cycle, and a write in the immediately preceding cycle is already visible. The address does not change.
- R7: A read with post-increment (0x5) responds like R6 and then advances the address by one, wrapping from 0xFF to 0x00.
- R8: Six post-increment reads from a base address return six adjacent registers in ascending order. This lets two 24-bit values, stored least significant byte first, be reassembled.
- R9: Opcodes 0x6 to 0xF, and any cycle with `cmd_valid` low, change neither the address nor the staged nibble. They cause no write and no response.
- R10: While `rst_n` is low, the address clears to 0x00, the staged nibble is discarded, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Opcode in upper nibble, payload in lower nibble |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_byte | output | 8 | Returned register contents |
| reg_addr | output | 8 | Current register address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` (combinational) |

## Verification
A wrong address nibble or a missed increment shows on `reg_addr` one cycle after the offending command, because that port is compared every clock. A stale or leaked staged nibble stays invisible until the next data-high command. At that command it shows either as a wrong `reg_wr_data` or as a strobe that should not be there. The bench's reference model catches that in the same cycle. A write that goes to the wrong place surfaces only at the next read of the affected register. For this reason every write sequence is followed by a read-back.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADDR_LO  = 4'h0,
        OP_ADDR_HI  = 4'h1,
        OP_DATA_LO  = 4'h2,
        OP_DATA_HI  = 4'h3,
        OP_READ     = 4'h4,
        OP_READ_INC = 4'h5
    } nrp_op_e;

    typedef struct packed {
        logic addr_lo;
        logic addr_hi;
        logic data_lo;
        logic data_hi;
        logic rd;
        logic rd_inc;
    } nrp_cmd_s;

endpackage

// File: rtl/nrp_decode.sv
module nrp_decode
    import nrp_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [OP_W+NIB_W-1:0] cmd_byte,
    output nrp_cmd_s              cmd,
    output logic [NIB_W-1:0]      payload
);

    localparam int BYTE_W = OP_W + NIB_W;

    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode  = cmd_byte[BYTE_W-1:NIB_W];
        payload = cmd_byte[NIB_W-1:0];
        cmd     = '0;
        if (cmd_valid) begin
            case (opcode)
                OP_ADDR_LO:  cmd.addr_lo = 1'b1;
                OP_ADDR_HI:  cmd.addr_hi = 1'b1;
                OP_DATA_LO:  cmd.data_lo = 1'b1;
                OP_DATA_HI:  cmd.data_hi = 1'b1;
                OP_READ:     cmd.rd      = 1'b1;
                OP_READ_INC: cmd.rd_inc  = 1'b1;
                default:     ;
            endcase
        end
    end

    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd == '0));

endmodule

// File: rtl/nrp_rsp.sv
module nrp_rsp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_byte
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_s;

    rsp_s rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = fire;
        if (fire) begin
            rsp_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_byte  = rsp_q.data;

    assert_read_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_valid && rsp_byte == $past(rd_data)));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);

endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
    import nrp_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [OP_W+NIB_W-1:0] cmd_byte,
    output logic                  rsp_valid,
    output logic [2*NIB_W-1:0]    rsp_byte,
    output logic [2*NIB_W-1:0]    reg_addr,
    output logic                  reg_wr_en,
    output logic [2*NIB_W-1:0]    reg_wr_data,
    input  logic [2*NIB_W-1:0]    reg_rd_data
);

    localparam int ADDR_W = 2 * NIB_W;
    localparam int DATA_W = 2 * NIB_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NIB_W-1:0]  stage;
        logic              stage_v;
    } port_state_s;

    nrp_cmd_s          cmd;
    logic [NIB_W-1:0]  payload;
    port_state_s       st_d, st_q;

    nrp_decode #(.NIB_W(NIB_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd       (cmd),
        .payload   (payload)
    );

    always_comb begin
        st_d = st_q;
        if (cmd.addr_lo) begin
            st_d.addr[NIB_W-1:0] = payload;
            st_d.stage_v         = 1'b0;
        end
        if (cmd.addr_hi) begin
            st_d.addr[ADDR_W-1:NIB_W] = payload;
        end
        if (cmd.data_lo) begin
            st_d.stage   = payload;
            st_d.stage_v = 1'b1;
        end
        if (cmd.data_hi) begin
            st_d.stage_v = 1'b0;
        end
        if (cmd.rd_inc) begin
            st_d.addr = st_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_addr    = st_q.addr;
    assign reg_wr_en   = cmd.data_hi & st_q.stage_v;
    assign reg_wr_data = {payload, st_q.stage};

    nrp_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (cmd.rd | cmd.rd_inc),
        .rd_data   (reg_rd_data),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );

    assert_addr_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.addr_lo |=> (reg_addr[NIB_W-1:0] == $past(payload)
                         && reg_addr[ADDR_W-1:NIB_W] == $past(reg_addr[ADDR_W-1:NIB_W])));

    assert_addr_high_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.addr_hi |=> (reg_addr[ADDR_W-1:NIB_W] == $past(payload)));

    assert_write_only_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (cmd_valid && cmd_byte[OP_W+NIB_W-1:NIB_W] == OP_DATA_HI));

    assert_write_keeps_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> $stable(reg_addr));

    assert_addr_lo_drops_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.addr_lo ##1 cmd.data_hi |-> !reg_wr_en);

    assert_write_consumes_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en ##1 cmd.data_hi |-> !reg_wr_en);

    assert_plain_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rd |=> $stable(reg_addr));

    assert_post_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rd_inc |=> (reg_addr == ADDR_W'($past(reg_addr) + ADDR_W'(1))));

    assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == '0) |=> ($stable(reg_addr) && !rsp_valid));

endmodule

// File: tb/sim_nibble_reg_port.sv
module sim_nibble_reg_port;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       rsp_valid;
    logic [7:0] rsp_byte;
    logic [7:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;

    logic [7:0] rf [0:255];

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int         m_addr;
    int         m_stage;
    bit         m_stv;
    int         m_mem [0:255];
    logic [7:0] last_rsp;

    always #(CLK_P/2) clk = ~clk;

    nibble_reg_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .rsp_valid   (rsp_valid),
        .rsp_byte    (rsp_byte),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    always_comb reg_rd_data = rf[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) rf[i] <= 8'((i * 7 + 3) & 255);
        end else if (reg_wr_en) begin
            rf[reg_addr] <= reg_wr_data;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input string tag);
        int  op;
        int  pl;
        bit  exp_we;
        bit  exp_rv;
        int  exp_rb;
        cmd_valid = v;
        cmd_byte  = b;
        op = int'(b[7:4]);
        pl = int'(b[3:0]);
        #1;
        exp_we = v && op == 3 && m_stv;
        chk(tag, "reg_addr", int'(reg_addr), m_addr);
        chk(tag, "reg_wr_en", int'(reg_wr_en), int'(exp_we));
        if (exp_we) chk(tag, "reg_wr_data", int'(reg_wr_data), pl * 16 + m_stage);
        exp_rv = v && (op == 4 || op == 5);
        exp_rb = m_mem[m_addr];
        if (exp_we) m_mem[m_addr] = pl * 16 + m_stage;
        if (v) begin
            case (op)
                0: begin m_addr = (m_addr & 8'hF0) | pl; m_stv = 1'b0; end
                1: m_addr = (m_addr & 8'h0F) | (pl << 4);
                2: begin m_stage = pl; m_stv = 1'b1; end
                3: m_stv = 1'b0;
                5: m_addr = (m_addr + 1) % 256;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rsp_valid", int'(rsp_valid), int'(exp_rv));
        if (exp_rv) chk(tag, "rsp_byte", int'(rsp_byte), exp_rb);
        last_rsp = rsp_byte;
    endtask

    task automatic set_addr(input int a, input string tag);
        step(1'b1, 8'(8'h00 | (a & 15)), tag);
        step(1'b1, 8'(8'h10 | ((a >> 4) & 15)), tag);
    endtask

    task automatic put(input int d, input string tag);
        step(1'b1, 8'(8'h20 | (d & 15)), tag);
        step(1'b1, 8'(8'h30 | ((d >> 4) & 15)), tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int trig;
        int stop;
        for (int i = 0; i < 256; i++) m_mem[i] = (i * 7 + 3) & 255;
        m_addr = 0; m_stage = 0; m_stv = 1'b0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "rsp_valid in reset", int'(rsp_valid), 0);
        chk("R10", "reg_addr in reset", int'(reg_addr), 0);
        rst_n = 1'b1;

        // R9: valid low ignored
        step(1'b0, 8'h35, "R9");
        step(1'b0, 8'h4A, "R9");
        // R2 / R1 / R6
        set_addr(8'hCA, "R2");
        step(1'b1, 8'h40, "R6");
        step(1'b1, 8'h40, "R6");
        // R3: write then immediate read-back
        put(8'hB7, "R3");
        step(1'b1, 8'h40, "R3");
        // R4: two bytes to one register
        put(8'h12, "R4");
        put(8'h43, "R4");
        step(1'b1, 8'h40, "R4");
        // R5: high without low, low discarded by address-low
        step(1'b1, 8'h39, "R5");
        step(1'b1, 8'h25, "R5");
        step(1'b1, 8'h0A, "R5");
        step(1'b1, 8'h3F, "R5");
        step(1'b1, 8'h40, "R5");
        put(8'h66, "R5");
        step(1'b1, 8'h3E, "R5");
        step(1'b1, 8'h40, "R5");
        // R9: unused opcodes ignored, staged nibble survives
        step(1'b1, 8'h21, "R9");
        step(1'b1, 8'h65, "R9");
        step(1'b1, 8'hF0, "R9");
        step(1'b1, 8'h8A, "R9");
        step(1'b1, 8'h3D, "R9");
        step(1'b1, 8'h40, "R9");
        // R7: increment with wrap
        set_addr(8'hFF, "R7");
        step(1'b1, 8'h50, "R7");
        step(1'b1, 8'h50, "R7");
        chk("R7", "addr after wrap", int'(reg_addr), 1);
        // R8: two 24-bit values, least significant byte first
        set_addr(8'h40, "R8"); put(8'h56, "R8");
        set_addr(8'h41, "R8"); put(8'h34, "R8");
        set_addr(8'h42, "R8"); put(8'h12, "R8");
        set_addr(8'h43, "R8"); put(8'hBC, "R8");
        set_addr(8'h44, "R8"); put(8'h9A, "R8");
        set_addr(8'h45, "R8"); put(8'h78, "R8");
        set_addr(8'h40, "R8");
        trig = 0; stop = 0;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 8'h50, "R8");
            trig = trig | (int'(last_rsp) << (8 * k));
        end
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 8'h50, "R8");
            stop = stop | (int'(last_rsp) << (8 * k));
        end
        chk("R8", "first 24-bit value", trig, 32'h123456);
        chk("R8", "second 24-bit value", stop, 32'h789ABC);
        chk("R8", "addr after six reads", int'(reg_addr), 8'h46);
        // R1: idle tail
        step(1'b0, 8'h00, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule